// File: doc/BRIEF.md
# External Data Bus Controller with Hold Handover

This block sits between a processor core and one external 16-bit data memory bus shared by two logical data spaces, X and Y. The core hands it one access at a time over a valid/ready request channel: a direction, a space select, a 14-bit word address and, for writes, the data. The block runs the access on the pins with active-low read and write strobes and lets the memory stretch reads with an active-low wait input. It then returns a one-cycle done pulse, which carries the captured word for reads.

A second master can take the whole bus. It pulls the hold request low and waits for the hold acknowledge. While the acknowledge is low, every shared pin of the block is left undriven. The address and space pins hold their last value between accesses and read zero after reset until the first access.

Request back-pressure: a request moves on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the block is idle, owns the bus and sees no hold request. The core must keep the request fields stable while `req_valid` is high and `req_ready` is low. The response channel has no back-pressure: `rsp_valid` is a single-cycle pulse that the core must take when it appears.

Top module: `xbh_bus_ctrl`

## Requirements
- R1: After reset the address pins read 0 and the space pin reads 0 until the first access. Both strobes, the bus-busy output and the hold acknowledge are high, `rsp_valid` is low and `req_ready` is high.
- R2: During an access, the space pin is 0 for X and 1 for Y, and the address pins carry the request address.
- R3: A read drives `bus_rd_n` low starting on the edge that accepts it. The read finishes on the first later edge at which `bus_wait_n` is 1, so it lasts 1 cycle plus one cycle per sampled 0. The data bus is captured on that edge and shown on `rsp_rdata` while `rsp_valid` is high in the cycle that follows.
- R4: A write drives `bus_wr_n` low for exactly one cycle with the write data on the data bus. `bus_wait_n` has no effect on writes, and `rsp_valid` pulses in the following cycle.
- R5: `bus_rd_n` and `bus_wr_n` are never low together. The block drives the data bus only while its write strobe is low.
- R6: Between accesses, including across a hold handover, the address and space pins keep the values of the last access.
- R7: A hold request seen while idle is acknowledged (`hold_ack_n` low) on the next edge. A hold request that arrives during an access leaves the acknowledge high until the edge that finishes that access, and that access completes normally.
- R8: While `hold_ack_n` is low, the space, address, data, read strobe and write strobe pins are all left undriven, and `req_ready` is low.
- R9: After `hold_req_n` returns high, `hold_ack_n` rises on the next edge while the pins stay undriven for one more cycle. Only after that does the block drive them again and raise `req_ready`.
- R10: `bus_strobe_n` is low exactly in the cycles where a read or write strobe of the block is low.
- R11: `rsp_valid` is never high in two consecutive cycles, and `req_ready` is low for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Block accepts a request this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 1 | 0 = X space, 1 = Y space |
| req_addr | input | 14 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid after a read |
| bus_space | inout | 1 | Space select pin, three-state |
| bus_addr | inout | 14 | Address pins, three-state |
| bus_data | inout | 16 | Bidirectional data pins |
| bus_rd_n | inout | 1 | Read strobe, active low, three-state |
| bus_wr_n | inout | 1 | Write strobe, active low, three-state |
| bus_wait_n | input | 1 | Wait input, 0 stretches a read |
| bus_strobe_n | output | 1 | Low while the block runs an access |
| hold_req_n | input | 1 | External master asks for the bus, active low |
| hold_ack_n | output | 1 | Bus granted to the external master, active low |

## Verification
The bench goes after the wait handling on reads. A controller that sampled the wait pin one edge late, or also applied it to writes, would return data or its done pulse a cycle off, and it would latch the wrong word. It raises a hold request in the middle of a stretched read. A design that granted at once would cut the access short and flag a float while the strobe is still low. It acts as the external master during the hold, driving its own values on all shared pins and reading them back, so any pin the block kept driving shows up as a mismatch. It also checks that the address pins come back holding the last address after the handover, and that the release waits out the turnaround cycle; an early redrive would show `req_ready` high too soon.

// File: rtl/xbh_pkg.sv
package xbh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACC    = 2'd1,
    ST_HOLD   = 2'd2,
    ST_RESUME = 2'd3
  } xbh_state_e;

endpackage

// File: rtl/xbh_seq.sv
module xbh_seq
  import xbh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       hold_req_n,
  input  logic       wait_n,
  output logic       req_ready,
  output logic       accept,
  output logic       finish,
  output logic       fin_read,
  output logic       rd_n,
  output logic       wr_n,
  output logic       drive_en,
  output logic       data_oe,
  output logic       strobe_n,
  output logic       hold_ack_n
);

  xbh_state_e state_q, state_d;
  logic       is_wr_q;

  // Only an idle, owned bus with no pending hold takes new work.
  assign req_ready = (state_q == ST_IDLE) && hold_req_n;
  assign accept    = req_valid && req_ready;

  // Writes ignore the wait pin; reads end on the first sampled 1.
  assign finish    = (state_q == ST_ACC) && (is_wr_q || wait_n);
  assign fin_read  = finish && !is_wr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!hold_req_n)  state_d = ST_HOLD;
        else if (accept)  state_d = ST_ACC;
      end
      ST_ACC: begin
        if (finish) state_d = hold_req_n ? ST_IDLE : ST_HOLD;
      end
      ST_HOLD: begin
        if (hold_req_n) state_d = ST_RESUME;
      end
      ST_RESUME: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) is_wr_q <= req_write;
    end
  end

  assign rd_n       = !((state_q == ST_ACC) && !is_wr_q);
  assign wr_n       = !((state_q == ST_ACC) &&  is_wr_q);
  assign strobe_n   = (state_q != ST_ACC);
  assign hold_ack_n = (state_q != ST_HOLD);
  assign drive_en   = (state_q == ST_IDLE) || (state_q == ST_ACC);
  assign data_oe    = (state_q == ST_ACC) && is_wr_q;

endmodule

// File: rtl/xbh_addr_hold.sv
module xbh_addr_hold #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              space_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              space_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);

  // Loaded only when a request is accepted, so pins keep the last access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      space_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      space_q <= space_in;
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

endmodule

// File: rtl/xbh_resp.sv
module xbh_resp #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              finish,
  input  logic              fin_read,
  input  logic [DATA_W-1:0] pin_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= finish;
      if (fin_read) rsp_rdata <= pin_data;
    end
  end

endmodule

// File: rtl/xbh_tri.sv
module xbh_tri #(
  parameter int W = 1
) (
  input  logic         en,
  input  logic [W-1:0] d,
  inout  wire  [W-1:0] pad
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pad[i] = en ? d[i] : 1'bz;
  end

endmodule

// File: rtl/xbh_bus_ctrl.sv
module xbh_bus_ctrl #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  inout  wire               bus_space,
  inout  wire  [ADDR_W-1:0] bus_addr,
  inout  wire  [DATA_W-1:0] bus_data,
  inout  wire               bus_rd_n,
  inout  wire               bus_wr_n,
  input  logic              bus_wait_n,
  output logic              bus_strobe_n,
  input  logic              hold_req_n,
  output logic              hold_ack_n
);

  logic              accept, finish, fin_read;
  logic              rd_n_int, wr_n_int, drive_en, data_oe;
  logic              space_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  xbh_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .hold_req_n (hold_req_n),
    .wait_n     (bus_wait_n),
    .req_ready  (req_ready),
    .accept     (accept),
    .finish     (finish),
    .fin_read   (fin_read),
    .rd_n       (rd_n_int),
    .wr_n       (wr_n_int),
    .drive_en   (drive_en),
    .data_oe    (data_oe),
    .strobe_n   (bus_strobe_n),
    .hold_ack_n (hold_ack_n)
  );

  xbh_addr_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .space_in (req_space),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .space_q  (space_q),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q)
  );

  xbh_resp #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .finish    (finish),
    .fin_read  (fin_read),
    .pin_data  (bus_data),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  xbh_tri #(.W(1))      u_pad_space (.en(drive_en), .d(space_q),  .pad(bus_space));
  xbh_tri #(.W(ADDR_W)) u_pad_addr  (.en(drive_en), .d(addr_q),   .pad(bus_addr));
  xbh_tri #(.W(1))      u_pad_rd    (.en(drive_en), .d(rd_n_int), .pad(bus_rd_n));
  xbh_tri #(.W(1))      u_pad_wr    (.en(drive_en), .d(wr_n_int), .pad(bus_wr_n));
  xbh_tri #(.W(DATA_W)) u_pad_data  (.en(data_oe),  .d(wdata_q),  .pad(bus_data));

endmodule

// File: rtl/xbh_bus_checker.sv
module xbh_bus_checker #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rd_n_int,
  input  logic              wr_n_int,
  input  logic              drive_en,
  input  logic              data_oe,
  input  logic              strobe_n,
  input  logic              hold_req_n,
  input  logic              hold_ack_n,
  input  logic [ADDR_W-1:0] addr_q
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n_int || wr_n_int); // R5

  AST_DATA_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!wr_n_int && drive_en)); // R5

  AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> (!drive_en && !data_oe && !req_ready)); // R8

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> !$past(hold_req_n)); // R7

  AST_RESUME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack_n) |-> (!drive_en && !req_ready)); // R9

  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n) == (!rd_n_int || !wr_n_int)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11

  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> !req_ready); // R11

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && $past(drive_en) && !$past(req_valid && req_ready)) |-> $stable(addr_q)); // R6

endmodule

bind xbh_bus_ctrl xbh_bus_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rd_n_int   (rd_n_int),
  .wr_n_int   (wr_n_int),
  .drive_en   (drive_en),
  .data_oe    (data_oe),
  .strobe_n   (bus_strobe_n),
  .hold_req_n (hold_req_n),
  .hold_ack_n (hold_ack_n),
  .addr_q     (addr_q)
);

// File: tb/xbh_bus_ctrl_tb.sv
module xbh_bus_ctrl_tb_top;

  localparam int AW = 14;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic          req_space = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          bus_wait_n = 1'b1;
  logic          hold_req_n = 1'b1;
  logic          req_ready, rsp_valid, bus_strobe_n, hold_ack_n;
  logic [DW-1:0] rsp_rdata;
  wire           bus_space, bus_rd_n, bus_wr_n;
  wire  [AW-1:0] bus_addr;
  wire  [DW-1:0] bus_data;

  // External master's own pin values during a handover.
  localparam logic [AW-1:0] EXT_ADDR = 14'h2A5C;
  localparam logic [DW-1:0] EXT_DATA = 16'hC3A5;

  int errors = 0;
  int checks = 0;
  logic          last_sp = 1'b0;
  logic [AW-1:0] last_ad = '0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] rd_pat(input logic sp, input logic [AW-1:0] ad);
    return {~ad[7:0], sp, ad[13:7]};
  endfunction

  wire ext_drv = !hold_ack_n;
  assign bus_addr  = ext_drv ? EXT_ADDR : {AW{1'bz}};
  assign bus_space = ext_drv ? 1'b1 : 1'bz;
  assign bus_rd_n  = ext_drv ? 1'b0 : 1'bz;
  assign bus_wr_n  = ext_drv ? 1'b1 : 1'bz;
  assign bus_data  = ext_drv ? EXT_DATA :
                     ((bus_rd_n == 1'b0) ? rd_pat(bus_space, bus_addr) : {DW{1'bz}});

  xbh_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_space(bus_space), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_wait_n(bus_wait_n),
    .bus_strobe_n(bus_strobe_n), .hold_req_n(hold_req_n), .hold_ack_n(hold_ack_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One access; hold_mid raises a hold request in the first strobe cycle.
  task automatic do_acc(input bit wr, input bit sp, input logic [AW-1:0] ad,
                        input logic [DW-1:0] wd, input int nw, input bit hold_mid);
    int last;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_space = sp; req_addr = ad; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    last = wr ? 0 : nw;
    for (int k = 0; k <= last; k++) begin
      if (wr) begin
        chk(bus_wr_n == 1'b0 && bus_rd_n == 1'b1, "R4", {bus_rd_n, bus_wr_n}, 2'b10);
        chk(bus_data == wd, "R4", bus_data, wd);
      end else begin
        chk(bus_rd_n == 1'b0 && bus_wr_n == 1'b1, "R3", {bus_rd_n, bus_wr_n}, 2'b01);
      end
      chk(bus_addr == ad && bus_space == sp, "R2", {bus_space, bus_addr}, {sp, ad});
      chk(bus_strobe_n == 1'b0, "R10", bus_strobe_n, 0);
      chk(rsp_valid == 1'b0 && req_ready == 1'b0, "R11", {rsp_valid, req_ready}, 0);
      if (k > 0) chk(hold_ack_n == 1'b1, "R7", hold_ack_n, 1);
      bus_wait_n = wr ? 1'b0 : ((k < nw) ? 1'b0 : 1'b1);
      if (hold_mid && k == 0) hold_req_n = 1'b0;
      @(negedge clk);
    end
    bus_wait_n = 1'b1;
    chk(rsp_valid == 1'b1, wr ? "R4" : "R3", rsp_valid, 1);
    if (!wr) chk(rsp_rdata == rd_pat(sp, ad), "R3", rsp_rdata, rd_pat(sp, ad));
    last_sp = sp; last_ad = ad;
    if (hold_mid) begin
      chk(hold_ack_n == 1'b0, "R7", hold_ack_n, 0);
    end else begin
      chk(bus_rd_n == 1'b1 && bus_wr_n == 1'b1 && bus_strobe_n == 1'b1, "R10",
          {bus_rd_n, bus_wr_n, bus_strobe_n}, 3'b111);
      chk(bus_addr == ad && bus_space == sp, "R6", {bus_space, bus_addr}, {sp, ad});
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11", rsp_valid, 0);
  endtask

  // Called with the acknowledge low; ends with the block driving again.
  task automatic hold_and_release;
    chk(bus_addr == EXT_ADDR && bus_space == 1'b1, "R8", {bus_space, bus_addr}, {1'b1, EXT_ADDR});
    chk(bus_rd_n == 1'b0 && bus_wr_n == 1'b1, "R8", {bus_rd_n, bus_wr_n}, 2'b01);
    chk(bus_data == EXT_DATA, "R8", bus_data, EXT_DATA);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 14'h0123;
    for (int k = 0; k < 3; k++) begin
      chk(req_ready == 1'b0 && bus_strobe_n == 1'b1, "R8", {req_ready, bus_strobe_n}, 2'b01);
      @(negedge clk);
    end
    req_valid = 1'b0;
    hold_req_n = 1'b1;
    @(negedge clk);
    chk(hold_ack_n == 1'b1 && req_ready == 1'b0, "R9", {hold_ack_n, req_ready}, 2'b10);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", req_ready, 1);
    chk(bus_addr == last_ad && bus_space == last_sp, "R6", {bus_space, bus_addr}, {last_sp, last_ad});
    chk(bus_rd_n == 1'b1 && bus_wr_n == 1'b1, "R9", {bus_rd_n, bus_wr_n}, 2'b11);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h1D0C5EED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bus_addr == '0 && bus_space == 1'b0, "R1", {bus_space, bus_addr}, 0);
    chk(bus_rd_n && bus_wr_n && bus_strobe_n && hold_ack_n, "R1",
        {bus_rd_n, bus_wr_n, bus_strobe_n, hold_ack_n}, 4'hF);
    chk(!rsp_valid && req_ready, "R1", {rsp_valid, req_ready}, 2'b01);

    // Directed: waitless and stretched reads, write ignoring wait.
    do_acc(1'b0, 1'b0, 14'h0005, '0, 0, 1'b0);
    do_acc(1'b0, 1'b1, 14'h3FFF, '0, 3, 1'b0);
    do_acc(1'b1, 1'b1, 14'h1234, 16'hBEEF, 0, 1'b0);

    // R7 hold from idle: acknowledge on the next edge.
    @(negedge clk);
    hold_req_n = 1'b0;
    @(negedge clk);
    chk(hold_ack_n == 1'b0, "R7", hold_ack_n, 0);
    hold_and_release();

    // R7 hold requested in the middle of a stretched read.
    do_acc(1'b0, 1'b0, 14'h2001, '0, 2, 1'b1);
    hold_and_release();
    // Hold requested during a write.
    do_acc(1'b1, 1'b0, 14'h0777, 16'h0F0F, 0, 1'b1);
    hold_and_release();

    // Random mix.
    for (int n = 0; n < 200; n++) begin
      bit            wr = 1'($urandom_range(0, 1));
      bit            sp = 1'($urandom_range(0, 1));
      logic [AW-1:0] ad = AW'($urandom());
      logic [DW-1:0] wd = DW'($urandom());
      int            nw = $urandom_range(0, 3);
      int            gap = $urandom_range(0, 2);
      do_acc(wr, sp, ad, wd, nw, 1'b0);
      repeat (gap) @(negedge clk);
      chk(bus_addr == last_ad && bus_space == last_sp, "R6",
          {bus_space, bus_addr}, {last_sp, last_ad});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule